// File: doc/BRIEF.md
# Hardwired Accumulator Processor Sequencer

This block is the hardwired control path of a 16-bit processor with a single accumulator. A 4-bit step counter is decoded into one-hot timing lines, and the three opcode bits of the held instruction are decoded into eight one-hot operation lines. Together with an indirect flag, these lines drive every register transfer. The block fetches from a word-addressed memory outside the block, resolves one level of indirection, and carries out the seven memory-reference operations: AND, ADD, LDA, STA, BUN, BSA and ISZ.

Register-reference instructions are passed to a companion unit. The block raises a one-cycle start strobe and presents the 12-bit operation field. The block itself stops running when bit 0 of that field is set, which is the halt operation. Input/output instructions do nothing here and only restart the step sequence.

The memory read path is combinational. The memory presents the word at the current address within the same step, and the block captures it at the end of that step. Writes take effect on the clock edge that closes the writing step.

Top module: `acc_seq_ctrl`

## Requirements
- R1: While reset is asserted, pc_o, ac_o, e_o and step_o are all zero, and running is 1. Execution therefore begins at address 0.
- R2: The timing of each instruction is fixed.
  - Fetch takes T0 to T2, and the PC increments once during fetch.
  - An instruction with opcode 7 takes 4 cycles.
  - STA and BUN take 5 cycles.
  - AND, ADD, LDA and BSA take 6 cycles.
  - ISZ takes 7 cycles.
- R3: The instruction word is laid out as follows.
  - Bit 15 is the indirect flag I.
  - Bits 14:12 are the opcode: AND=0, ADD=1, LDA=2, STA=3, BUN=4, BSA=5, ISZ=6.
  - Bits 11:0 are the address.
  - When I=1 and the opcode is 0 to 6, the effective address is bits 11:0 of the memory word at the address field.
- R4: AND sets AC to AC AND M[EA]. LDA sets AC to M[EA]. Neither changes E. ADD sets {E,AC} to AC + M[EA], so E receives the carry-out.
- R5: STA writes AC to M[EA].
- R6: BUN sets PC to EA.
- R7: BSA writes the address of the following instruction, zero-extended, to M[EA]. Execution then continues at EA+1.
- R8: ISZ writes M[EA]+1 (modulo 2^16) back to M[EA]. When that result is zero, the next instruction is skipped.
- R9: Opcode 7 with I=0 gives one rr_start pulse at step T3, with rr_code equal to bits 11:0. The next fetch follows. If bit 0 is set, the block halts.
- R10: Opcode 7 with I=1 changes no register and no memory word, and execution proceeds to the next instruction.
- R11: Once halted, running is 0. The PC, AC, E and step stay frozen, and no memory write occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_rdata | input | 16 | Memory read word for mem_addr, valid in the same cycle |
| mem_wdata | output | 16 | Memory write word |
| mem_we | output | 1 | Memory write enable |
| rr_start | output | 1 | Register-reference start strobe |
| rr_code | output | 12 | Register-reference operation field |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag E |
| step_o | output | 4 | Sequence counter value |
| running | output | 1 | Start-stop flag; 0 once halted |

## Verification
The assertions assume that the memory returns a stable word for the address shown in the same cycle. They also assume that reset is the only way to restart a halted block, and that no outside agent alters memory while the block runs.

The bench's memory model provides exactly that behaviour. Random programs are constrained so that operands fall in a data window, pointers fall in a separate window that STA never targets, and every program ends in two halt words. This way, an ISZ skip can never run past the end of the program.

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          rr_start,
  output logic [AW-1:0] rr_code,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ac_o,
  output logic          e_o,
  output logic [SW-1:0] step_o,
  output logic          running
);
  localparam int NT = 1 << SW;

  logic          s, ind, e;
  logic [SW-1:0] sc;
  logic [AW-1:0] ar, pc;
  logic [DW-1:0] ir, dr, ac;
  logic [NT-1:0] t;
  logic [7:0]    d;

  always_comb begin
    t = '0;
    t[sc] = 1'b1;
    d = '0;
    d[ir[DW-2 -: 3]] = 1'b1;
  end

  wire mref  = ~d[7];
  wire rr_go = s & t[3] & d[7] & ~ind;
  wire clr   = (t[3] & d[7]) | (t[4] & (d[3] | d[4])) |
               (t[5] & (d[0] | d[1] | d[2] | d[5])) | (t[6] & d[6]);

  assign mem_addr  = ar;
  assign mem_we    = s & ((t[4] & (d[3] | d[5])) | (t[6] & d[6]));
  assign mem_wdata = d[3] ? ac : d[5] ? DW'(pc) : dr;
  assign rr_start  = rr_go;
  assign rr_code   = ir[AW-1:0];
  assign pc_o      = pc;
  assign ac_o      = ac;
  assign e_o       = e;
  assign step_o    = sc;
  assign running   = s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s   <= 1'b1;
      sc  <= '0;
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      dr  <= '0;
      ac  <= '0;
      e   <= 1'b0;
      ind <= 1'b0;
    end else if (s) begin
      sc <= clr ? '0 : sc + 1'b1;
      if (t[0]) ar <= pc;
      if (t[1]) begin
        ir <= mem_rdata;
        pc <= pc + 1'b1;
      end
      if (t[2]) begin
        ar  <= ir[AW-1:0];
        ind <= ir[DW-1];
      end
      if (t[3] & mref & ind) ar <= mem_rdata[AW-1:0];
      if (rr_go & ir[0]) s <= 1'b0;
      if (t[4] & (d[0] | d[1] | d[2] | d[6])) dr <= mem_rdata;
      if (t[4] & d[4]) pc <= ar;
      if (t[4] & d[5]) ar <= ar + 1'b1;
      if (t[5] & d[0]) ac <= ac & dr;
      if (t[5] & d[1]) {e, ac} <= {1'b0, ac} + {1'b0, dr};
      if (t[5] & d[2]) ac <= dr;
      if (t[5] & d[5]) pc <= ar;
      if (t[5] & d[6]) dr <= dr + 1'b1;
      if (t[6] & d[6] & (dr == '0)) pc <= pc + 1'b1;
    end
  end

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s |-> (t[NT-1:7] == '0));
  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s && sc == SW'(1)) |=> (pc == AW'($past(pc) + 1'b1)));
  // R9
  rr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_start |=> (sc == '0));
  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s |=> (!s && $stable(pc) && $stable(ac) && $stable(sc) && !mem_we));
  // R5
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (sc == SW'(4) || sc == SW'(6)));
endmodule

// File: tb/acc_seq_ctrl_test.sv
module acc_seq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] mem_addr, rr_code, pc_o;
  logic [15:0] mem_rdata, mem_wdata, ac_o;
  logic mem_we, rr_start, e_o, running;
  logic [3:0] step_o;

  logic [15:0] mem [0:4095];
  logic [15:0] rmem [0:4095];
  logic [11:0] x_pc;
  logic [15:0] x_ac;
  logic x_e;
  logic [11:0] last_rr;
  int rr_cnt = 0, checks = 0, errors = 0;

  always #10 clk = ~clk;

  acc_seq_ctrl uut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .rr_start(rr_start), .rr_code(rr_code),
    .pc_o(pc_o), .ac_o(ac_o), .e_o(e_o), .step_o(step_o), .running(running));

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (rr_start) begin
      rr_cnt <= rr_cnt + 1;
      last_rr <= rr_code;
    end
  end

  function automatic logic [15:0] ins(int op, bit i, int a);
    return {i, 3'(op), 12'(a)};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 4096; k++) mem[k] = 16'h0;
  endtask

  task automatic iss(output int cyc, output int rrn);
    logic [15:0] w, v;
    logic [11:0] ea;
    bit halted = 0;
    x_pc = 0; x_ac = 0; x_e = 0; cyc = 0; rrn = 0;
    for (int n = 0; n < 3000 && !halted; n++) begin
      w = rmem[x_pc];
      x_pc = x_pc + 1;
      ea = w[11:0];
      if (w[14:12] == 3'd7) begin
        cyc += 4;
        if (!w[15]) begin
          rrn++;
          if (w[0]) halted = 1;
        end
      end else begin
        if (w[15]) ea = rmem[ea][11:0];
        case (w[14:12])
          3'd0: begin x_ac = x_ac & rmem[ea]; cyc += 6; end
          3'd1: begin {x_e, x_ac} = {1'b0, x_ac} + {1'b0, rmem[ea]}; cyc += 6; end
          3'd2: begin x_ac = rmem[ea]; cyc += 6; end
          3'd3: begin rmem[ea] = x_ac; cyc += 5; end
          3'd4: begin x_pc = ea; cyc += 5; end
          3'd5: begin rmem[ea] = {4'h0, x_pc}; x_pc = ea + 1; cyc += 6; end
          default: begin
            v = rmem[ea] + 1; rmem[ea] = v;
            if (v == 0) x_pc = x_pc + 1;
            cyc += 7;
          end
        endcase
      end
    end
  endtask

  task automatic run_prog(string tag);
    int ecyc, err, cyc, bad;
    for (int k = 0; k < 4096; k++) rmem[k] = mem[k];
    iss(ecyc, err);
    @(negedge clk);
    rst_n = 1'b0;
    rr_cnt = 0;
    @(negedge clk);
    chk("R1", "reset pc", pc_o, 0);
    chk("R1", "reset ac/e/step", {ac_o, e_o, step_o}, 0);
    chk("R1", "reset running", running, 1);
    rst_n = 1'b1;
    cyc = 0;
    while (running && cyc < 20000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    chk("R2", {tag, " cycles"}, cyc, ecyc);
    chk(tag, "pc", pc_o, x_pc);
    chk(tag, "ac", ac_o, x_ac);
    chk(tag, "e", e_o, x_e);
    chk("R9", {tag, " rr pulses"}, rr_cnt, err);
    bad = 0;
    for (int k = 0; k < 4096; k++) if (mem[k] !== rmem[k]) bad++;
    chk(tag, "memory mismatches", bad, 0);
  endtask

  initial begin
    int done = 0;
    fork
      begin
        #50ms;
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    // R4 arithmetic, carry into E
    clear_mem();
    mem[0] = ins(2, 0, 12'h800); mem[1] = ins(1, 0, 12'h801);
    mem[2] = ins(0, 0, 12'h802); mem[3] = ins(3, 0, 12'h803); mem[4] = 16'h7001;
    mem[12'h800] = 16'hFFF0; mem[12'h801] = 16'h0025; mem[12'h802] = 16'h00FF;
    run_prog("R4");
    chk("R4", "carry", e_o, 1);
    chk("R5", "stored word", mem[12'h803], 16'h0015);

    // R3 indirect, R6 branch
    clear_mem();
    mem[0] = ins(2, 1, 12'h900); mem[1] = ins(4, 0, 5);
    mem[2] = ins(3, 0, 12'h806); mem[3] = ins(3, 0, 12'h806); mem[4] = 16'h7001;
    mem[5] = ins(3, 1, 12'h901); mem[6] = 16'h7001;
    mem[12'h900] = 16'h0805; mem[12'h901] = 16'h0807; mem[12'h805] = 16'hBEEF;
    run_prog("R3");
    chk("R6", "branch skipped store", mem[12'h806], 0);
    chk("R3", "indirect store", mem[12'h807], 16'hBEEF);

    // R7 subroutine call and indirect return
    clear_mem();
    mem[0] = ins(5, 0, 12'h100); mem[1] = 16'h7001;
    mem[12'h101] = ins(1, 0, 12'h800); mem[12'h102] = ins(4, 1, 12'h100);
    mem[12'h800] = 16'h1234;
    run_prog("R7");
    chk("R7", "return slot", mem[12'h100], 16'h0001);
    chk("R7", "ac after call", ac_o, 16'h1234);

    // R8 increment and skip
    clear_mem();
    mem[0] = ins(6, 0, 12'h800); mem[1] = ins(2, 0, 12'h801);
    mem[2] = ins(6, 1, 12'h900); mem[3] = ins(2, 0, 12'h802); mem[4] = 16'h7001;
    mem[12'h800] = 16'hFFFF; mem[12'h801] = 16'h5555; mem[12'h802] = 16'h0005;
    mem[12'h900] = 16'h0802;
    run_prog("R8");
    chk("R8", "wrap to zero", mem[12'h800], 0);
    chk("R8", "no skip path", ac_o, 16'h0006);

    // R10 io no-op, R9 register-reference strobe and halt
    clear_mem();
    mem[0] = ins(2, 0, 12'h800); mem[1] = 16'hF800; mem[2] = 16'h7800;
    mem[3] = 16'hF400; mem[4] = 16'h7001; mem[12'h800] = 16'h00A5;
    run_prog("R10");
    chk("R10", "ac kept", ac_o, 16'h00A5);
    chk("R9", "halt code", last_rr, 12'h001);

    // R11 freeze after halt
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R11", "no write", mem_we, 0);
      chk("R11", "pc/step frozen", {pc_o, step_o}, {12'h005, 4'h0});
      chk("R11", "running low", running, 0);
    end

    // random programs
    void'($urandom(32'd1234));
    for (int p = 0; p < 8; p++) begin
      clear_mem();
      for (int k = 0; k < 16; k++) mem[12'h900 + k] = 16'h0800 + 16'($urandom_range(0, 63));
      for (int k = 0; k < 64; k++)
        mem[12'h800 + k] = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      for (int k = 0; k < 24; k++) begin
        int ops[5] = '{0, 1, 2, 3, 6};
        bit ib = 1'($urandom_range(0, 1));
        mem[k] = ins(ops[$urandom_range(0, 4)], ib,
                     ib ? 12'h900 + $urandom_range(0, 15) : 12'h800 + $urandom_range(0, 63));
      end
      mem[24] = 16'h7001; mem[25] = 16'h7001;
      run_prog("R4/R5/R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule